// File: doc/BRIEF.md
# Serial programming command engine

This block sits behind a two-wire serial programming port once the chip has been put into program mode. An external programmer toggles a serial clock and drives a data line. The block assembles six-bit commands from that line and decodes them. For commands that carry a payload, it frames the payload: a leading zero start bit, the data or address bits, and a trailing zero stop bit. It either shifts write data and addresses in, or shifts read data out through an output enable.

The block keeps its own program counter, which any request it issues uses as the memory address. Requests reach a simple memory port as a one-cycle strobe with an operation code, an address and write data. The nonvolatile array and its programming timing sit outside this block. All serial inputs are sampled into the system clock domain. Serial edges are detected there, so the serial clock must run well below the system clock.

Top module: `serprog_cmd_engine`

## Requirements
- R1: While `pgm_en` is low, the program counter (seen on `mem_addr`) is zero. `ser_doe` is low, no request is issued and serial edges are ignored. A partly received command or payload is discarded, and framing restarts at a command when `pgm_en` returns high.
- R2: A command is six bits, sampled on falling edges of `ser_clk` with the least significant bit first. Bit 5 is ignored for every opcode except the write-data and read-data commands.
- R3: Opcode 02h/22h (write data) takes a 16-clock payload: a start bit, 14 data bits sent LSB first, and a stop bit. Its end raises one request with `mem_op`=1, `mem_wdata` equal to the data, and `mem_addr` equal to the program counter.
- R4: For opcodes 02h and 04h (bit 5 = 0), the program counter is left unchanged after the payload. For 22h and 24h (bit 5 = 1), it advances by one after the payload, wrapping at the counter width.
- R5: Opcode 06h (or 26h) advances the program counter by one and issues no request.
- R6: Opcode 1Dh (or 3Dh) takes a 24-clock payload: a start bit, 22 address bits sent LSB first, and a stop bit. The program counter is loaded with that address. No request is issued.
- R7: Opcode 04h/24h (read data) raises a request with `mem_op`=2 at the current program counter as soon as the command is decoded. `mem_rdata` is sampled one cycle after that strobe. The word is sent LSB first, with one bit driven per rising serial edge on clocks 2 to 15 of the 16-clock payload. `ser_doe` is high only on those clocks.
- R8: Opcodes 05h, 09h, 08h, 18h and 0Ah issue a one-cycle request with no payload, tagged with the current program counter. Their `mem_op` codes are 3 (row erase), 4 (bulk erase), 5 (start self-timed programming), 6 (start host-timed programming) and 7 (end programming).
- R9: After a command that has a payload, serial edges are ignored for `GAP_CYC` system clocks.
- R10: An opcode that matches no command is dropped, with no request and no change to the program counter.
- R11: Opcode 00h/20h (load configuration) takes a 16-clock payload framed like write data. It issues one request with `mem_op`=0 and the data on `mem_wdata`, and leaves the program counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_en | input | 1 | Program mode active |
| ser_clk | input | 1 | Serial clock from the programmer |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial read data out |
| ser_doe | output | 1 | Output enable for the serial data pin |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_op | output | 3 | Request operation code |
| mem_addr | output | ADDR_W | Program counter, used as the request address |
| mem_wdata | output | DATA_W | Write data for load requests |
| mem_rdata | input | DATA_W | Read data from the memory port |

## Verification
The assertions check several rules on every cycle: the quiet state while program mode is off, that a request strobe is a single cycle, that the address is stable under a request, that the program counter moves by at most one after a request, and that the data pin is never driven out of program mode. Other properties can only be shown by the bench scenarios. These include opcode decoding with the don't-care top bit, payload bit ordering, the read-out window, and the rejection of stray edges inside the command-to-payload gap. The same applies to abandoning a half-received command when program mode drops.

// File: rtl/serprog_pkg.sv
// Shared types and opcode constants for the serial programming command engine.
// Assumes a fixed six-bit command word; only the low five bits select the command.
package serprog_pkg;

    localparam int CMD_BITS = 6;

    // Memory request operation codes (values are visible on the port)
    typedef enum logic [2:0] {
        MOP_LOAD_CFG   = 3'd0,
        MOP_LOAD_DATA  = 3'd1,
        MOP_READ       = 3'd2,
        MOP_ROW_ERASE  = 3'd3,
        MOP_BULK_ERASE = 3'd4,
        MOP_PROG_INT   = 3'd5,
        MOP_PROG_EXT   = 3'd6,
        MOP_PROG_END   = 3'd7
    } mem_op_e;

    // Kind of payload that follows a command
    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_CFG   = 3'd1,
        PK_WDATA = 3'd2,
        PK_RDATA = 3'd3,
        PK_ADDR  = 3'd4
    } pay_kind_e;

    // Framing state
    typedef enum logic [1:0] {
        FS_CMD = 2'd0,
        FS_GAP = 2'd1,
        FS_PAY = 2'd2
    } frame_st_e;

    localparam logic [4:0] OPC_LOAD_CFG  = 5'h00;
    localparam logic [4:0] OPC_LOAD_DATA = 5'h02;
    localparam logic [4:0] OPC_READ      = 5'h04;
    localparam logic [4:0] OPC_INC       = 5'h06;
    localparam logic [4:0] OPC_LOAD_PC   = 5'h1D;
    localparam logic [4:0] OPC_PROG_INT  = 5'h08;
    localparam logic [4:0] OPC_PROG_EXT  = 5'h18;
    localparam logic [4:0] OPC_PROG_END  = 5'h0A;
    localparam logic [4:0] OPC_BULK      = 5'h09;
    localparam logic [4:0] OPC_ROW       = 5'h05;

    // Decoded view of one command word
    typedef struct packed {
        pay_kind_e kind;     // payload that follows
        logic      has_op;   // immediate request without payload
        mem_op_e   op;       // operation for the immediate request
        logic      inc_now;  // advance program counter at once
        logic      j;        // advance after payload (data commands only)
    } cmd_dec_t;

    // Translate a command word into actions; unknown words decode to nothing
    function automatic cmd_dec_t decode_cmd(input logic [CMD_BITS-1:0] c);
        cmd_dec_t d;
        d.kind    = PK_NONE;
        d.has_op  = 1'b0;
        d.op      = MOP_LOAD_CFG;
        d.inc_now = 1'b0;
        d.j       = 1'b0;
        case (c[4:0])
            OPC_LOAD_CFG:  d.kind = PK_CFG;
            OPC_LOAD_DATA: begin d.kind = PK_WDATA; d.j = c[5]; end
            OPC_READ:      begin d.kind = PK_RDATA; d.j = c[5]; end
            OPC_INC:       d.inc_now = 1'b1;
            OPC_LOAD_PC:   d.kind = PK_ADDR;
            OPC_PROG_INT:  begin d.has_op = 1'b1; d.op = MOP_PROG_INT;   end
            OPC_PROG_EXT:  begin d.has_op = 1'b1; d.op = MOP_PROG_EXT;   end
            OPC_PROG_END:  begin d.has_op = 1'b1; d.op = MOP_PROG_END;   end
            OPC_BULK:      begin d.has_op = 1'b1; d.op = MOP_BULK_ERASE; end
            OPC_ROW:       begin d.has_op = 1'b1; d.op = MOP_ROW_ERASE;  end
            default:       ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/serprog_edge_sync.sv
// Brings the serial clock and data into the system clock domain and flags
// serial clock edges. Assumes STAGES >= 2 and a serial clock whose levels
// each last several system clocks. Data is delayed by the same stages as the
// clock so that the flagged edge and the data bit line up.
module serprog_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdat_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdat_s
);

    logic [STAGES:0]   ck_pipe;
    logic [STAGES-1:0] dt_pipe;

    // Shift serial clock and data through the synchroniser chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
        end else begin
            ck_pipe <= {ck_pipe[STAGES-1:0], sclk_in};
            dt_pipe <= {dt_pipe[STAGES-2:0], sdat_in};
        end
    end

    // Compare synchronised level with its previous value to find edges
    always_comb begin
        sclk_rise = ck_pipe[STAGES-1] & ~ck_pipe[STAGES];
        sclk_fall = ~ck_pipe[STAGES-1] & ck_pipe[STAGES];
        sdat_s    = dt_pipe[STAGES-1];
    end

endmodule

// File: rtl/serprog_pc.sv
// Program counter for the command engine. Clear beats load, load beats
// increment. Increment wraps at the counter width.
module serprog_pc #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] pc
);

    // Update the counter from the highest-priority request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pc <= '0;
        end else if (load) begin
            pc <= load_val;
        end else if (inc) begin
            pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/serprog_frame.sv
// Command and payload framing state machine. Collects a command from the
// falling edges, waits GAP_CYC system clocks for payload commands, then counts
// payload clocks: a start bit, the body, and a stop bit. For reads it drives
// one bit per rising edge inside the body window. Assumes GAP_CYC >= 2 so that
// the read word is captured before the payload starts. Leaving program mode
// returns the machine to the command phase.
module serprog_frame
    import serprog_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int ADDR_W  = 22,
    parameter int GAP_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output mem_op_e           mem_op,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_load_val,
    output logic              pc_inc,
    output logic              dout,
    output logic              doe
);

    localparam int DATA_LEN = DATA_W + 2;
    localparam int ADDR_LEN = ADDR_W + 2;
    localparam int MAX_LEN  = (ADDR_LEN > DATA_LEN) ? ADDR_LEN : DATA_LEN;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);
    localparam int SH_W     = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int GAP_W    = $clog2(GAP_CYC + 1);

    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_LEN - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_TOP  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ADDR_TOP  = CNT_W'(ADDR_W);
    localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_CYC - 1);

    frame_st_e             st;
    logic [CNT_W-1:0]      bcnt;
    logic [CMD_BITS-1:0]   cmd_sh;
    logic [SH_W-1:0]       pay_sh;
    pay_kind_e             kind;
    logic                  j_q;
    logic [GAP_W-1:0]      gap_cnt;
    logic [DATA_W-1:0]     rd_sh;
    logic                  rd_cap;
    logic                  rd_pend;

    logic [CMD_BITS-1:0]   cmd_full;
    cmd_dec_t              dec;
    logic [CNT_W-1:0]      pay_last;
    logic [CNT_W-1:0]      body_top;
    logic                  body_bit;

    // Decode the word that the current falling edge would complete
    always_comb begin
        cmd_full = {din, cmd_sh[CMD_BITS-1:1]};
        dec      = decode_cmd(cmd_full);
    end

    // Payload length and body window for the active payload kind
    always_comb begin
        pay_last = (kind == PK_ADDR) ? ADDR_LAST : DATA_LAST;
        body_top = (kind == PK_ADDR) ? ADDR_TOP  : DATA_TOP;
        body_bit = (bcnt != '0) && (bcnt <= body_top);
    end

    // Framing state machine, request generation and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            st          <= FS_CMD;
            bcnt        <= '0;
            cmd_sh      <= '0;
            pay_sh      <= '0;
            kind        <= PK_NONE;
            j_q         <= 1'b0;
            gap_cnt     <= '0;
            rd_sh       <= '0;
            rd_cap      <= 1'b0;
            rd_pend     <= 1'b0;
            mem_req     <= 1'b0;
            mem_op      <= MOP_LOAD_CFG;
            mem_wdata   <= '0;
            pc_load     <= 1'b0;
            pc_load_val <= '0;
            pc_inc      <= 1'b0;
            dout        <= 1'b0;
            doe         <= 1'b0;
        end else begin
            mem_req <= 1'b0;
            pc_load <= 1'b0;
            pc_inc  <= 1'b0;
            rd_cap  <= 1'b0;
            rd_pend <= rd_cap;
            if (rd_pend) begin
                rd_sh <= mem_rdata;
            end
            case (st)
                FS_CMD: begin
                    if (fall) begin
                        cmd_sh <= cmd_full;
                        if (bcnt == CMD_LAST) begin
                            bcnt <= '0;
                            if (dec.kind == PK_NONE) begin
                                mem_req <= dec.has_op;
                                if (dec.has_op) begin
                                    mem_op <= dec.op;
                                end
                                pc_inc <= dec.inc_now;
                            end else begin
                                kind    <= dec.kind;
                                j_q     <= dec.j;
                                gap_cnt <= '0;
                                st      <= FS_GAP;
                                if (dec.kind == PK_RDATA) begin
                                    mem_req <= 1'b1;
                                    mem_op  <= MOP_READ;
                                    rd_cap  <= 1'b1;
                                end
                            end
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                FS_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        st   <= FS_PAY;
                        bcnt <= '0;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                FS_PAY: begin
                    if (rise && kind == PK_RDATA) begin
                        if (bcnt != '0 && bcnt <= DATA_TOP) begin
                            doe   <= 1'b1;
                            dout  <= rd_sh[0];
                            rd_sh <= rd_sh >> 1;
                        end else begin
                            doe <= 1'b0;
                        end
                    end
                    if (fall) begin
                        if (body_bit) begin
                            pay_sh <= {din, pay_sh[SH_W-1:1]};
                        end
                        if (bcnt == pay_last) begin
                            st   <= FS_CMD;
                            bcnt <= '0;
                            doe  <= 1'b0;
                            case (kind)
                                PK_WDATA: begin
                                    mem_req   <= 1'b1;
                                    mem_op    <= MOP_LOAD_DATA;
                                    mem_wdata <= pay_sh[SH_W-1 -: DATA_W];
                                    pc_inc    <= j_q;
                                end
                                PK_CFG: begin
                                    mem_req   <= 1'b1;
                                    mem_op    <= MOP_LOAD_CFG;
                                    mem_wdata <= pay_sh[SH_W-1 -: DATA_W];
                                end
                                PK_RDATA: pc_inc <= j_q;
                                PK_ADDR: begin
                                    pc_load     <= 1'b1;
                                    pc_load_val <= pay_sh[SH_W-1 -: ADDR_W];
                                end
                                default: ;
                            endcase
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                default: st <= FS_CMD;
            endcase
        end
    end

endmodule

// File: rtl/serprog_cmd_engine.sv
// Top of the serial programming command engine: edge synchroniser, framing
// state machine and program counter. The program counter is the memory
// address for every request. Assumes mem_rdata reflects mem_addr one cycle
// after a read strobe.
module serprog_cmd_engine
    import serprog_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int ADDR_W      = 22,
    parameter int GAP_CYC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_doe,
    output logic              mem_req,
    output logic [2:0]        mem_op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic              s_rise;
    logic              s_fall;
    logic              s_din;
    logic              pc_load;
    logic [ADDR_W-1:0] pc_load_val;
    logic              pc_inc;
    mem_op_e           op_w;

    serprog_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (ser_clk),
        .sdat_in   (ser_din),
        .sclk_rise (s_rise),
        .sclk_fall (s_fall),
        .sdat_s    (s_din)
    );

    serprog_frame #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .GAP_CYC (GAP_CYC)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (pgm_en),
        .rise        (s_rise),
        .fall        (s_fall),
        .din         (s_din),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_op      (op_w),
        .mem_wdata   (mem_wdata),
        .pc_load     (pc_load),
        .pc_load_val (pc_load_val),
        .pc_inc      (pc_inc),
        .dout        (ser_dout),
        .doe         (ser_doe)
    );

    serprog_pc #(
        .ADDR_W (ADDR_W)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!pgm_en),
        .load     (pc_load),
        .load_val (pc_load_val),
        .inc      (pc_inc),
        .pc       (mem_addr)
    );

    // Present the operation code as a plain vector
    always_comb mem_op = op_w;

endmodule

// File: rtl/serprog_chk.sv
// Property checker for the command engine, attached by bind.
module serprog_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pgm_en,
    input logic              ser_doe,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1
    pc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_en |=> mem_addr == '0);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_en |=> (!ser_doe && !mem_req));

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3
    req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && pgm_en && $past(pgm_en)) |-> $stable(mem_addr));

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && pgm_en) |=>
            (mem_addr == $past(mem_addr) || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R7
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_doe |-> $past(pgm_en));

endmodule

bind serprog_cmd_engine serprog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgm_en   (pgm_en),
    .ser_doe  (ser_doe),
    .mem_req  (mem_req),
    .mem_addr (mem_addr)
);

// File: tb/sim_serprog_cmd_engine.sv
module sim_serprog_cmd_engine;

    localparam int  CLK_PERIOD = 10;
    localparam int  DATA_W     = 14;
    localparam int  ADDR_W     = 22;
    localparam int  GAP        = 32;
    localparam int  HALF       = 6;
    localparam int  WDOG       = 100000;

    typedef struct packed {
        logic [5:0]        cmd;
        logic [ADDR_W-1:0] pay;
        logic              hreq;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
        logic [ADDR_W-1:0] pc;
    } vec_t;

    // Command stream walked in order; pc carries over between entries
    localparam vec_t VEC [0:13] = '{
        '{6'h1D, 22'h000100, 1'b0, 3'd0, 22'h0,      14'h0,    22'h000100}, // R6
        '{6'h02, 22'h001ABC, 1'b1, 3'd1, 22'h000100, 14'h1ABC, 22'h000100}, // R3 R4
        '{6'h22, 22'h000123, 1'b1, 3'd1, 22'h000100, 14'h0123, 22'h000101}, // R4
        '{6'h06, 22'h0,      1'b0, 3'd0, 22'h0,      14'h0,    22'h000102}, // R5
        '{6'h26, 22'h0,      1'b0, 3'd0, 22'h0,      14'h0,    22'h000103}, // R2 R5
        '{6'h05, 22'h0,      1'b1, 3'd3, 22'h000103, 14'h0,    22'h000103}, // R8
        '{6'h29, 22'h0,      1'b1, 3'd4, 22'h000103, 14'h0,    22'h000103}, // R2 R8
        '{6'h08, 22'h0,      1'b1, 3'd5, 22'h000103, 14'h0,    22'h000103}, // R8
        '{6'h38, 22'h0,      1'b1, 3'd6, 22'h000103, 14'h0,    22'h000103}, // R8
        '{6'h0A, 22'h0,      1'b1, 3'd7, 22'h000103, 14'h0,    22'h000103}, // R8
        '{6'h20, 22'h003FFF, 1'b1, 3'd0, 22'h000103, 14'h3FFF, 22'h000103}, // R11
        '{6'h0F, 22'h0,      1'b0, 3'd0, 22'h0,      14'h0,    22'h000103}, // R10
        '{6'h3D, 22'h3FFFFF, 1'b0, 3'd0, 22'h0,      14'h0,    22'h3FFFFF}, // R6
        '{6'h22, 22'h002AAA, 1'b1, 3'd1, 22'h3FFFFF, 14'h2AAA, 22'h000000}  // R4 wrap
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pgm_en = 1'b0;
    logic              ser_clk = 1'b0;
    logic              ser_din = 1'b0;
    logic              ser_dout;
    logic              ser_doe;
    logic              mem_req;
    logic [2:0]        mem_op;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    int                checks = 0;
    int                errors = 0;
    int                req_cnt = 0;
    logic [2:0]        last_op = '0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [DATA_W-1:0] last_wd = '0;
    bit                done = 1'b0;

    // Memory read model: fixed function of the address
    function automatic logic [DATA_W-1:0] rd_model(input logic [ADDR_W-1:0] a);
        return (a[DATA_W-1:0] * 14'd41) ^ 14'h1555;
    endfunction

    assign mem_rdata = rd_model(mem_addr);

    always #(CLK_PERIOD / 2) clk = ~clk;

    serprog_cmd_engine #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .GAP_CYC (GAP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgm_en    (pgm_en),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout),
        .ser_doe   (ser_doe),
        .mem_req   (mem_req),
        .mem_op    (mem_op),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Record every request strobe
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            req_cnt   <= req_cnt + 1;
            last_op   <= mem_op;
            last_addr <= mem_addr;
            last_wd   <= mem_wdata;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sys_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b1;
        sys_wait(HALF);
        ser_clk = 1'b0;
        sys_wait(HALF);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) ser_bit(c[i]);
    endtask

    task automatic send_pay(input logic [ADDR_W-1:0] v, input int nbits);
        ser_bit(1'b0);
        for (int i = 0; i < nbits; i++) ser_bit(v[i]);
        ser_bit(1'b0);
    endtask

    // Clock out a read payload, checking the enable window and bits
    task automatic read_pay(input logic [DATA_W-1:0] exp, input string req);
        logic [DATA_W-1:0] got;
        int                oe_bad;
        got    = '0;
        oe_bad = 0;
        ser_din = 1'b0;
        for (int k = 0; k < DATA_W + 2; k++) begin
            ser_clk = 1'b1;
            sys_wait(HALF);
            if (k >= 1 && k <= DATA_W) begin
                got[k-1] = ser_dout;
                if (ser_doe !== 1'b1) oe_bad++;
            end else if (ser_doe !== 1'b0) begin
                oe_bad++;
            end
            ser_clk = 1'b0;
            sys_wait(HALF);
        end
        check(req, "read word", 32'(got), 32'(exp));
        check("R7", "enable window misses", 32'(oe_bad), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        sys_wait(4);
        // R1 reset state
        check("R1", "req in reset", 32'(mem_req), 32'd0);
        check("R1", "doe in reset", 32'(ser_doe), 32'd0);
        rst_n = 1'b1;
        sys_wait(4);
        check("R1", "pc after reset", 32'(mem_addr), 32'd0);

        // R1 edges ignored outside program mode
        base = req_cnt;
        send_cmd(6'h09);
        sys_wait(10);
        check("R1", "req while off", 32'(req_cnt - base), 32'd0);

        pgm_en = 1'b1;
        sys_wait(4);

        // Table of command vectors
        for (int i = 0; i < 14; i++) begin
            base = req_cnt;
            send_cmd(VEC[i].cmd);
            if (VEC[i].cmd[4:0] == 5'h1D) begin
                sys_wait(GAP + 8);
                send_pay(VEC[i].pay, ADDR_W);
            end else if (VEC[i].cmd[4:0] == 5'h00 || VEC[i].cmd[4:0] == 5'h02) begin
                sys_wait(GAP + 8);
                send_pay(VEC[i].pay, DATA_W);
            end
            sys_wait(10);
            check("R2", $sformatf("vec %0d req count", i), 32'(req_cnt - base), 32'(VEC[i].hreq));
            if (VEC[i].hreq) begin
                check("R8", $sformatf("vec %0d op", i), 32'(last_op), 32'(VEC[i].op));
                check("R3", $sformatf("vec %0d addr", i), 32'(last_addr), 32'(VEC[i].addr));
                if (VEC[i].op <= 3'd1)
                    check("R3", $sformatf("vec %0d wdata", i), 32'(last_wd), 32'(VEC[i].wd));
            end
            check("R4", $sformatf("vec %0d pc", i), 32'(mem_addr), 32'(VEC[i].pc));
        end

        // R7 read without increment
        send_cmd(6'h1D); sys_wait(GAP + 8); send_pay(22'h40, ADDR_W); sys_wait(10);
        base = req_cnt;
        send_cmd(6'h04);
        sys_wait(GAP + 8);
        check("R7", "read req count", 32'(req_cnt - base), 32'd1);
        check("R7", "read op", 32'(last_op), 32'd2);
        check("R7", "read addr", 32'(last_addr), 32'h40);
        read_pay(rd_model(22'h40), "R7");
        sys_wait(10);
        check("R4", "pc after 04h", 32'(mem_addr), 32'h40);

        // R4 read with increment
        send_cmd(6'h24);
        sys_wait(GAP + 8);
        read_pay(rd_model(22'h40), "R4");
        sys_wait(10);
        check("R4", "pc after 24h", 32'(mem_addr), 32'h41);

        // R9 stray clock inside the gap is ignored
        base = req_cnt;
        send_cmd(6'h02);
        ser_bit(1'b1);
        sys_wait(GAP + 8);
        send_pay(22'h0555, DATA_W);
        sys_wait(10);
        check("R9", "gap req count", 32'(req_cnt - base), 32'd1);
        check("R9", "gap wdata", 32'(last_wd), 32'h0555);

        // R1 dropping program mode mid-command
        send_cmd(6'h1D); sys_wait(GAP + 8); send_pay(22'h77, ADDR_W); sys_wait(10);
        check("R6", "pc load", 32'(mem_addr), 32'h77);
        ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
        pgm_en = 1'b0;
        sys_wait(4);
        check("R1", "pc cleared", 32'(mem_addr), 32'd0);
        pgm_en = 1'b1;
        sys_wait(4);
        send_cmd(6'h06);
        sys_wait(10);
        check("R1", "framing restart", 32'(mem_addr), 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule